// File: doc/BRIEF.md
# Dual-Mode Transmit Word Serializer

This block takes 8b/10b-coded words from a protocol device and sends them out one bit at a time. The serial bit clock is modelled as a synchronous enable, `bit_en`, on the system clock. A word period is ten `bit_en` pulses. The block counts those pulses and derives the word-rate reference clock from them, which it presents on `ref_clk`. The reference clock is high for bit slots 0 to 4 and low for slots 5 to 9. Its rising edge falls on the word boundary.

The parallel side has two formats, chosen by `narrow_mode`:

- **Wide format:** the whole 10-bit word is captured on the rising edge of the reference clock.
- **Narrow format:** only the five low data lines are used. One half-word is taken on the rising edge and the other on the falling edge. The two halves are joined before serialization.

A pattern-source input, `pat_en`, makes the block ignore the parallel data. While it is high, the block serializes words from an internal 7-bit pseudo-random generator. The reference clock is generated internally and brought out, so a source can time its data against it.

Top module: `txser_top`

## Requirements
- R1: With `narrow_mode` low and `pat_en` low, `tx_data[9:0]` is captured at each rising edge of `ref_clk` (the `bit_en` pulse that ends slot 9). It is shifted out in full during the word period that begins at the following rising edge.
- R2: With `narrow_mode` high and `pat_en` low, the block builds each word from two captures of `tx_data[4:0]`. The capture at a rising edge supplies word bits 0 to 4. The capture at the next falling edge (the pulse that ends slot 4) supplies bits 5 to 9. The joined word is staged at the next rising edge. `tx_data[9:5]` has no effect on the output.
- R3: Each word leaves on `ser_out` bit 0 first and bit 9 last. The output shows bit k during slot k and advances by exactly one bit per `bit_en` pulse.
- R4: The shift register reloads once every ten `bit_en` pulses, with no gap slots. `ref_clk` is high in slots 0 to 4 and low in slots 5 to 9, and it rises only on the reload pulse.
- R5: While `pat_en` is high at a rising edge, the word staged there comes from the pattern generator, and `tx_data` is ignored. The generator has 7 bits of state and starts at all ones. Each step outputs the top state bit, then shifts the state left and feeds in the XOR of the two top bits. Ten steps make one word, and the first step gives bit 0. The state advances only at rising edges where `pat_en` is high.
- R6: Latency is counted from the capture edge of a word (in narrow format, the edge that captures its low half) to the end of bit 9 on `ser_out`. It is 20 `bit_en` pulses in wide format and 30 in narrow format.
- R7: While `rst_n` is low, `ser_out` is 0, `ref_clk` is 1 and `word_strobe` is 0. After reset, `ser_out` stays 0 until the first captured word reaches the shift register.
- R8: A cycle without `bit_en` changes neither `ser_out` nor the slot position.
- R9: `word_strobe` is high for exactly the one cycle after each shift-register reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial bit-time enable; one pulse per transmitted bit |
| narrow_mode | input | 1 | 0 selects 10-bit captures, 1 selects 5-bit captures on both reference edges |
| pat_en | input | 1 | 1 substitutes internal pattern words for the parallel data |
| tx_data | input | 10 | Parallel coded data; only bits 4:0 are used in narrow format |
| ser_out | output | 1 | Serial data, bit 0 of each word first |
| ref_clk | output | 1 | Derived word-rate reference clock |
| word_strobe | output | 1 | One-cycle pulse after each word load |

## Verification
The bench places a lone set bit 9 in a stream of zero words and counts enable pulses from its capture edge to its appearance on the line. A stage too few or too many shifts that count away from 19 (wide) or 29 (narrow). The same count catches halves swapped at the join or taken on the wrong edge, because the marker bit would surface early or never.

In narrow format the unused upper data lines carry busy junk. A design that let them through would corrupt the serial stream against the reference model.

Runs with `bit_en` dropping one cycle in two and one in three expose any shift or slot advance made without an enable. Pattern runs with changing parallel data show whether that data leaks in, or whether the generator steps at the wrong rate.

// File: rtl/txser_pkg.sv
package txser_pkg;

  localparam int unsigned TXS_WORD_W = 10;
  localparam int unsigned TXS_HALF_W = TXS_WORD_W / 2;
  localparam int unsigned TXS_PH_W   = $clog2(TXS_WORD_W);
  localparam int unsigned TXS_LFSR_W = 7;

  typedef logic [TXS_WORD_W-1:0] txs_word_t;
  typedef logic [TXS_HALF_W-1:0] txs_half_t;
  typedef logic [TXS_PH_W-1:0]   txs_phase_t;
  typedef logic [TXS_LFSR_W-1:0] txs_lfsr_t;

  // Reference-clock edge events, each one bit_en pulse wide
  typedef struct packed {
    logic rise;
    logic fall;
  } ref_edge_t;

  // One generator step: shift left, feed in XOR of the two top bits
  function automatic txs_lfsr_t lfsr_step(input txs_lfsr_t s);
    return {s[TXS_LFSR_W-2:0], s[TXS_LFSR_W-1] ^ s[TXS_LFSR_W-2]};
  endfunction

  // Word built from successive top bits, first step in bit 0
  function automatic txs_word_t lfsr_word(input txs_lfsr_t s);
    txs_lfsr_t st;
    txs_word_t w;
    st = s;
    w  = '0;
    for (int i = 0; i < TXS_WORD_W; i++) begin
      w[i] = st[TXS_LFSR_W-1];
      st   = lfsr_step(st);
    end
    return w;
  endfunction

  // State after one full word of steps
  function automatic txs_lfsr_t lfsr_skip(input txs_lfsr_t s);
    txs_lfsr_t st;
    st = s;
    for (int i = 0; i < TXS_WORD_W; i++) begin
      st = lfsr_step(st);
    end
    return st;
  endfunction

endpackage

// File: rtl/txs_phase_gen.sv
module txs_phase_gen
  import txser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  output txs_phase_t phase,
  output ref_edge_t  edges,
  output logic       ref_clk
);

  localparam txs_phase_t PH_LAST = TXS_PH_W'(TXS_WORD_W - 1);
  localparam txs_phase_t PH_FALL = TXS_PH_W'(TXS_HALF_W - 1);
  localparam txs_phase_t PH_HALF = TXS_PH_W'(TXS_HALF_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (bit_en) begin
      phase <= (phase == PH_LAST) ? '0 : phase + TXS_PH_W'(1);
    end
  end

  assign edges.rise = bit_en && (phase == PH_LAST);
  assign edges.fall = bit_en && (phase == PH_FALL);
  assign ref_clk    = (phase < PH_HALF);

endmodule

// File: rtl/txs_word_stage.sv
module txs_word_stage
  import txser_pkg::*;
#(
  parameter txs_lfsr_t SEED = '1
)(
  input  logic      clk,
  input  logic      rst_n,
  input  ref_edge_t edges,
  input  logic      narrow_mode,
  input  logic      pat_en,
  input  txs_word_t tx_data,
  output txs_word_t stage_word
);

  txs_half_t lo_q;
  txs_half_t hi_q;
  txs_lfsr_t lfsr_q;
  txs_word_t joined;
  txs_word_t pat_word;
  txs_word_t next_word;

  // Per-bit source select: wide capture or the two held halves
  for (genvar g = 0; g < TXS_HALF_W; g++) begin : g_join
    assign joined[g]              = narrow_mode ? lo_q[g] : tx_data[g];
    assign joined[g + TXS_HALF_W] = narrow_mode ? hi_q[g] : tx_data[g + TXS_HALF_W];
  end

  assign pat_word  = lfsr_word(lfsr_q);
  assign next_word = pat_en ? pat_word : joined;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      hi_q       <= '0;
      lfsr_q     <= SEED;
      stage_word <= '0;
    end else begin
      if (edges.rise) begin
        stage_word <= next_word;
        lo_q       <= tx_data[TXS_HALF_W-1:0];
        if (pat_en) begin
          lfsr_q <= lfsr_skip(lfsr_q);
        end
      end
      if (edges.fall) begin
        hi_q <= tx_data[TXS_HALF_W-1:0];
      end
    end
  end

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
  import txser_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      load,
  input  txs_word_t load_word,
  output txs_word_t shreg,
  output logic      ser_out,
  output logic      word_strobe
);

  txs_word_t shift_nxt;

  for (genvar g = 0; g < TXS_WORD_W; g++) begin : g_shift
    if (g == TXS_WORD_W - 1) begin : g_top
      assign shift_nxt[g] = 1'b0;
    end else begin : g_mid
      assign shift_nxt[g] = shreg[g + 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      word_strobe <= 1'b0;
    end else begin
      word_strobe <= load;
      if (load) begin
        shreg <= load_word;
      end else if (bit_en) begin
        shreg <= shift_nxt;
      end
    end
  end

  assign ser_out = shreg[0];

endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter txs_lfsr_t PAT_SEED = '1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  narrow_mode,
  input  logic                  pat_en,
  input  logic [TXS_WORD_W-1:0] tx_data,
  output logic                  ser_out,
  output logic                  ref_clk,
  output logic                  word_strobe
);

  txs_phase_t phase_q;
  ref_edge_t  edge_ev;
  txs_word_t  stage_word;
  txs_word_t  shreg_q;

  txs_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .phase   (phase_q),
    .edges   (edge_ev),
    .ref_clk (ref_clk)
  );

  txs_word_stage #(.SEED(PAT_SEED)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .edges       (edge_ev),
    .narrow_mode (narrow_mode),
    .pat_en      (pat_en),
    .tx_data     (tx_data),
    .stage_word  (stage_word)
  );

  txs_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .load        (edge_ev.rise),
    .load_word   (stage_word),
    .shreg       (shreg_q),
    .ser_out     (ser_out),
    .word_strobe (word_strobe)
  );

endmodule

// File: rtl/txser_checker.sv
module txs_checker
  import txser_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rise,
  input logic       ser_out,
  input logic       ref_clk,
  input logic       word_strobe,
  input txs_phase_t phase,
  input txs_word_t  shreg
);

  txs_phase_t en_cnt;
  logic [1:0] loads;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cnt <= '0;
      loads  <= '0;
    end else begin
      if (rise) begin
        en_cnt <= '0;
      end else if (bit_en) begin
        en_cnt <= en_cnt + TXS_PH_W'(1);
      end
      if (rise && loads != 2'd2) begin
        loads <= loads + 2'd1;
      end
    end
  end

  p_ten_per_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> en_cnt == TXS_PH_W'(TXS_WORD_W - 1));

  p_wrap_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (phase == '0) && ref_clk);

  p_ref_rise_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk) |-> word_strobe);

  p_bit_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rise) |=> ser_out == $past(shreg[1]));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out) && $stable(phase));

  p_quiet_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loads < 2'd2) |-> !ser_out);

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> word_strobe);

  p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> !word_strobe);

endmodule

bind txser_top txs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .rise        (edge_ev.rise),
  .ser_out     (ser_out),
  .ref_clk     (ref_clk),
  .word_strobe (word_strobe),
  .phase       (phase_q),
  .shreg       (shreg_q)
);

// File: tb/txser_top_tb.sv
module txser_top_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       bit_en;
  logic       narrow_mode;
  logic       pat_en;
  logic [9:0] tx_data;
  wire        ser_out;
  wire        ref_clk;
  wire        word_strobe;

  txser_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .narrow_mode (narrow_mode),
    .pat_en      (pat_en),
    .tx_data     (tx_data),
    .ser_out     (ser_out),
    .ref_clk     (ref_clk),
    .word_strobe (word_strobe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: slot counter, queue of pending words, current word
  int m_ph, m_cur, m_lo, m_hi, m_lfsr, m_ser, m_ref, m_stb;
  int m_pend[$];

  function automatic int next_pattern();
    int w = 0;
    for (int i = 0; i < 10; i++) begin
      int b, fb;
      b  = (m_lfsr >> 6) & 1;
      fb = b ^ ((m_lfsr >> 5) & 1);
      w  = w | (b << i);
      m_lfsr = ((m_lfsr << 1) | fb) & 127;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    m_stb = 0;
    if (!rst_n) begin
      m_ph = 0; m_cur = 0; m_lo = 0; m_hi = 0; m_lfsr = 127;
      m_pend.delete();
      m_pend.push_back(0);
    end else if (bit_en) begin
      if (m_ph == 9) begin
        m_cur = m_pend.pop_front();
        if (pat_en)           m_pend.push_back(next_pattern());
        else if (narrow_mode) m_pend.push_back((m_hi << 5) | m_lo);
        else                  m_pend.push_back(int'(tx_data));
        m_lo  = int'(tx_data) & 31;
        m_ph  = 0;
        m_stb = 1;
      end else begin
        if (m_ph == 4) m_hi = int'(tx_data) & 31;
        m_ph++;
      end
    end
    m_ser = (m_cur >> m_ph) & 1;
    m_ref = (m_ph < 5) ? 1 : 0;
  end

  // Stimulus state
  int  idx = 0;
  int  mk_idx = -100;
  int  mk_cnt = -1;
  int  en_mode = 0;
  int  cyc = 0;
  bit  marker_mode = 0;
  bit  presenting_mk = 0;
  bit  cmp_on = 0;
  bit  last_en = 0;
  bit  last_ref = 1;
  bit  last_rst = 0;
  bit  last_stb = 0;
  logic prev_ser = 0;

  function automatic logic [9:0] word_of(input int i);
    if (marker_mode) return (i == mk_idx) ? 10'h200 : 10'h000;
    return 10'((i * 173 + 91) ^ (i << 3));
  endfunction

  function automatic string ser_tag();
    if (pat_en) return "R5 R3";
    if (narrow_mode) return "R2 R3";
    return "R1 R3";
  endfunction

  task automatic step();
    bit en_n;
    @(negedge clk);
    cyc++;
    if (cmp_on) begin
      check(ser_tag(), 32'(ser_out), 32'(m_ser));
      check("R4", 32'(ref_clk), 32'(m_ref));
      check("R9", 32'(word_strobe), 32'(m_stb));
      if (rst_n && last_rst && !last_en) check("R8", 32'(ser_out), 32'(prev_ser));
    end
    // Latency of the marker word (bit 9 alone set among zero words)
    if (mk_cnt >= 0) begin
      if (last_en) mk_cnt++;
      if (ser_out === 1'b1) begin
        check("R6", 32'(mk_cnt), narrow_mode ? 32'd29 : 32'd19);
        mk_cnt = -1;
      end
    end
    if (word_strobe && presenting_mk) mk_cnt = 0;
    // Feed the parallel side in step with the reference clock
    if (!narrow_mode) begin
      if (word_strobe) idx++;
      tx_data = word_of(idx);
      presenting_mk = marker_mode && (idx == mk_idx);
    end else begin
      if (word_strobe) begin
        tx_data = {5'b10101, 5'(word_of(idx) >> 5)};
        presenting_mk = 0;
      end else if (!ref_clk && last_ref) begin
        idx++;
        tx_data = {5'b01011, 5'(word_of(idx))};
        presenting_mk = marker_mode && (idx == mk_idx);
      end
    end
    if (en_mode == 0)      en_n = 1'b1;
    else if (en_mode == 1) en_n = cyc[0];
    else                   en_n = (cyc % 3) != 0;
    bit_en   = en_n;
    last_en  = en_n;
    last_ref = ref_clk;
    last_stb = word_strobe;
    prev_ser = ser_out;
    last_rst = rst_n;
  endtask

  task automatic run_words(input int n);
    int seen = 0;
    while (seen < n) begin
      step();
      if (last_stb) seen++;
    end
  endtask

  task automatic marker_run();
    marker_mode = 1;
    mk_idx = idx + 3;
    run_words(8);
    check("R6", 32'(mk_cnt), 32'hFFFF_FFFF);
    marker_mode = 0;
  endtask

  task automatic reset_pulse();
    rst_n = 1'b0;
    repeat (3) begin
      step();
      check("R7", 32'(ser_out), 32'd0);
      check("R7", 32'(ref_clk), 32'd1);
      check("R7", 32'(word_strobe), 32'd0);
    end
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    checks++;
    fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; narrow_mode = 1'b0; pat_en = 1'b0; tx_data = '0;
    reset_pulse();
    cmp_on = 1;
    // R7: quiet output until a captured word is shifted
    run_words(1);
    check("R7", 32'(ser_out), 32'd0);
    // R1 wide captures, continuous enable
    run_words(20);
    marker_run();
    // R2 narrow captures with junk on the upper lines
    narrow_mode = 1'b1;
    run_words(20);
    marker_run();
    // R8 gapped enables in both formats
    en_mode = 1;
    run_words(10);
    marker_run();
    narrow_mode = 1'b0;
    run_words(10);
    marker_run();
    // R5 pattern source
    en_mode = 2;
    pat_en = 1'b1;
    run_words(20);
    narrow_mode = 1'b1;
    run_words(10);
    pat_en = 1'b0;
    run_words(10);
    // Reset in the middle of traffic
    reset_pulse();
    en_mode = 0;
    narrow_mode = 1'b0;
    run_words(6);
    finish_run();
  end

endmodule